// File: doc/BRIEF.md
# IDE PIO Cycle Timing Generator

This block produces the address-setup phase, the read or write strobe and the recovery hold-off for programmed-I/O cycles on two IDE channels. Each channel carries two drives. A host-side requester starts a cycle by naming a drive and a direction. The generator then steps through three phases: address setup, the active strobe and recovery. It pulses `done` once the cycle has finished and it is idle again.

Timing comes from small register banks that are loaded through a byte-wide write port. Each bank holds a setup byte and a timing byte. The setup byte keeps its clock code in the two top bits. The timing byte holds the active count in its upper nibble and the recovery count in its lower nibble. Drives 0 and 1 on the primary channel each have a bank of their own. Drives 2 and 3 on the secondary channel share one bank. A strap input selects a silicon variant whose recovery phase lasts one clock longer than programmed.

Top module: `pio_timing_gen`

## Requirements
- R1: After reset, every bank reads back 0x00, and a cycle on any drive runs 4 setup, 16 active and 16 recovery clocks, with `busy`, `done` and all strobes low before the first request.
- R2: Setup bits [7:6] select the setup length: 2'b00 gives 4 clocks, 2'b10 gives 3, 2'b01 gives 2 and 2'b11 gives 5.
- R3: When a setup register is written with `cfg_setup_only` high, only bits [7:6] change and bits [5:0] keep their old value. Otherwise the whole byte is replaced.
- R4: Timing byte bits [7:4] set the active clocks and bits [3:0] set the recovery clocks, and a nibble of 0 stands for 16.
- R5: An active nibble of 1 gives 2 active clocks.
- R6: A recovery nibble of 1 gives 2 recovery clocks when the decoded active count is above 3, and stays at 1 clock otherwise.
- R7: While `rev_plus1` is high, recovery lasts one clock longer than the value from R4 and R6, up to 17.
- R8: Register address is {bank[1:0], sel}, where sel 0 is the setup byte and sel 1 is the timing byte. Drive 0 uses bank 0 and drive 1 uses bank 1. Drives 2 and 3 both use bank 2, and bank 3 is not writable.
- R9: An accepted cycle asserts `cyc_setup`, then `cyc_rd` (read) or `cyc_wr` (write), then holds `busy` with no strobe for recovery. `done` is then high for exactly one cycle, the first idle cycle.
- R10: A request is accepted only while `busy` is low. A request made during a cycle is dropped, and it neither extends nor restarts that cycle.
- R11: A register write made during a cycle leaves that cycle's timing unchanged and applies from the next accepted cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rev_plus1 | input | 1 | Adds one recovery clock when high |
| cfg_we | input | 1 | Register write strobe |
| cfg_setup_only | input | 1 | Setup write touches bits [7:6] only |
| cfg_addr | input | 3 | Write address {bank, sel} |
| cfg_wdata | input | 8 | Write data |
| cfg_raddr | input | 3 | Read address {bank, sel} |
| cfg_rdata | output | 8 | Read data for the addressed register |
| req_valid | input | 1 | Cycle request |
| req_drive | input | 2 | Drive number 0 to 3 |
| req_write | input | 1 | 1 for a write cycle, 0 for a read cycle |
| busy | output | 1 | A cycle is in progress |
| cyc_setup | output | 1 | Address setup phase |
| cyc_rd | output | 1 | Read strobe |
| cyc_wr | output | 1 | Write strobe |
| done | output | 1 | One-cycle pulse at the end of a cycle |

## Verification
The bench measures the length of each phase for nibble values at the edges of the encoding: 0, which must mean 16, an active nibble of 1, and a recovery nibble of 1 with the active count on both sides of 3. A decoder that took these values literally would produce zero-length or one-clock phases. It also checks the setup code order 10/01, and a decoder that swapped those codes would produce wrong setup lengths. It checks that the two secondary drives see the same timing, and a design that gave them separate banks would fail this. Register writes and requests are injected in the middle of a cycle. A design that used live register values would stretch or cut the running cycle, and one that accepted a request while busy would restart it or add a second `done`.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int DATA_W    = 8;
    localparam int BANK_W    = 2;
    localparam int ADDR_W    = BANK_W + 1;
    localparam int NUM_BANKS = 3;
    localparam int NUM_SLOTS = 1 << BANK_W;
    localparam int CNT_W     = 5;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ACTIVE,
        PH_RECOV
    } phase_e;

    typedef struct packed {
        logic [CNT_W-1:0] setup_clk;
        logic [CNT_W-1:0] active_clk;
        logic [CNT_W-1:0] recov_clk;
        logic             is_write;
    } cycle_plan_t;

    // Two-bit nonlinear setup code to clock count.
    function automatic logic [CNT_W-1:0] setup_clocks(input logic [1:0] code);
        case (code)
            2'b00:   return CNT_W'(4);
            2'b10:   return CNT_W'(3);
            2'b01:   return CNT_W'(2);
            default: return CNT_W'(5);
        endcase
    endfunction

    // A zero nibble stands for sixteen clocks.
    function automatic logic [CNT_W-1:0] nib_clocks(input logic [3:0] n);
        return (n == 4'd0) ? CNT_W'(16) : {1'b0, n};
    endfunction

    function automatic logic [CNT_W-1:0] active_clocks(input logic [3:0] an);
        logic [CNT_W-1:0] a;
        a = nib_clocks(an);
        return (a == CNT_W'(1)) ? CNT_W'(2) : a;
    endfunction

    function automatic logic [CNT_W-1:0] recov_clocks(input logic [3:0] an,
                                                      input logic [3:0] rn,
                                                      input logic       plus1);
        logic [CNT_W-1:0] a;
        logic [CNT_W-1:0] r;
        a = nib_clocks(an);
        r = nib_clocks(rn);
        if (a > CNT_W'(3) && r == CNT_W'(1))
            r = CNT_W'(2);
        return r + {{(CNT_W-1){1'b0}}, plus1};
    endfunction

    function automatic logic [BANK_W-1:0] drive_bank(input logic [1:0] drive);
        return drive[1] ? BANK_W'(2) : {{(BANK_W-1){1'b0}}, drive[0]};
    endfunction

endpackage

// File: rtl/pio_regfile.sv
module pio_regfile
    import pio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_setup_only,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [ADDR_W-1:0] cfg_raddr,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic [BANK_W-1:0] lk_bank,
    output logic [1:0]        lk_setup_code,
    output logic [DATA_W-1:0] lk_timing
);

    logic [DATA_W-1:0] setup_q  [NUM_SLOTS];
    logic [DATA_W-1:0] timing_q [NUM_SLOTS];

    logic [BANK_W-1:0] wbank;
    logic [BANK_W-1:0] rbank;
    assign wbank = cfg_addr[ADDR_W-1:1];
    assign rbank = cfg_raddr[ADDR_W-1:1];

    for (genvar b = 0; b < NUM_SLOTS; b++) begin : g_bank
        if (b < NUM_BANKS) begin : g_live
            always_ff @(posedge clk) begin
                if (rst) begin
                    setup_q[b]  <= '0;
                    timing_q[b] <= '0;
                end else if (cfg_we && wbank == BANK_W'(b)) begin
                    if (cfg_addr[0])
                        timing_q[b] <= cfg_wdata;
                    else if (cfg_setup_only)
                        setup_q[b] <= {cfg_wdata[DATA_W-1:DATA_W-2], setup_q[b][DATA_W-3:0]};
                    else
                        setup_q[b] <= cfg_wdata;
                end
            end
        end else begin : g_hole
            assign setup_q[b]  = '0;
            assign timing_q[b] = '0;
        end
    end

    assign cfg_rdata     = cfg_raddr[0] ? timing_q[rbank] : setup_q[rbank];
    assign lk_setup_code = setup_q[lk_bank][DATA_W-1:DATA_W-2];
    assign lk_timing     = timing_q[lk_bank];

    // R3: a setup-only write leaves the low six bits of its register alone
    a_r3_setup_low_kept: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_setup_only && !cfg_addr[0] && wbank < BANK_W'(NUM_BANKS))
        |=> (setup_q[$past(wbank)][DATA_W-3:0] == $past(setup_q[wbank][DATA_W-3:0])));

endmodule

// File: rtl/pio_sequencer.sv
module pio_sequencer
    import pio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  cycle_plan_t       plan,
    output logic              busy,
    output logic              cyc_setup,
    output logic              cyc_rd,
    output logic              cyc_wr,
    output logic              done
);

    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;
    cycle_plan_t      plan_q;
    logic             done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            plan_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (req_valid) begin
                        plan_q  <= plan;
                        cnt_q   <= plan.setup_clk - CNT_W'(1);
                        phase_q <= PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    if (cnt_q == '0) begin
                        cnt_q   <= plan_q.active_clk - CNT_W'(1);
                        phase_q <= PH_ACTIVE;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                PH_ACTIVE: begin
                    if (cnt_q == '0) begin
                        cnt_q   <= plan_q.recov_clk - CNT_W'(1);
                        phase_q <= PH_RECOV;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                default: begin
                    if (cnt_q == '0) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
            endcase
        end
    end

    assign busy      = (phase_q != PH_IDLE);
    assign cyc_setup = (phase_q == PH_SETUP);
    assign cyc_rd    = (phase_q == PH_ACTIVE) && !plan_q.is_write;
    assign cyc_wr    = (phase_q == PH_ACTIVE) &&  plan_q.is_write;
    assign done      = done_q;

    // R9: at most one of setup, read strobe and write strobe at a time
    a_r9_phase_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cyc_setup, cyc_rd, cyc_wr}));

    // R9: a strobe always starts straight out of the setup phase
    a_r9_strobe_after_setup: assert property (@(posedge clk) disable iff (rst)
        $rose(cyc_rd || cyc_wr) |-> $past(cyc_setup));

    // R9: done marks the first idle cycle after a busy one
    a_r9_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R10: a new setup phase only begins from idle
    a_r10_no_restart: assert property (@(posedge clk) disable iff (rst)
        $rose(cyc_setup) |-> !$past(busy));

endmodule

// File: rtl/pio_timing_gen.sv
module pio_timing_gen
    import pio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rev_plus1,
    input  logic              cfg_we,
    input  logic              cfg_setup_only,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [ADDR_W-1:0] cfg_raddr,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              req_valid,
    input  logic [1:0]        req_drive,
    input  logic              req_write,
    output logic              busy,
    output logic              cyc_setup,
    output logic              cyc_rd,
    output logic              cyc_wr,
    output logic              done
);

    logic [1:0]        sel_code;
    logic [DATA_W-1:0] sel_timing;
    cycle_plan_t       plan;

    pio_regfile u_regs (
        .clk            (clk),
        .rst            (rst),
        .cfg_we         (cfg_we),
        .cfg_setup_only (cfg_setup_only),
        .cfg_addr       (cfg_addr),
        .cfg_wdata      (cfg_wdata),
        .cfg_raddr      (cfg_raddr),
        .cfg_rdata      (cfg_rdata),
        .lk_bank        (drive_bank(req_drive)),
        .lk_setup_code  (sel_code),
        .lk_timing      (sel_timing)
    );

    always_comb begin
        plan.setup_clk  = setup_clocks(sel_code);
        plan.active_clk = active_clocks(sel_timing[7:4]);
        plan.recov_clk  = recov_clocks(sel_timing[7:4], sel_timing[3:0], rev_plus1);
        plan.is_write   = req_write;
    end

    pio_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .plan      (plan),
        .busy      (busy),
        .cyc_setup (cyc_setup),
        .cyc_rd    (cyc_rd),
        .cyc_wr    (cyc_wr),
        .done      (done)
    );

endmodule

// File: tb/pio_timing_gen_test.sv
module pio_timing_gen_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rev_plus1 = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_setup_only = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [2:0] cfg_raddr = '0;
    logic [7:0] cfg_rdata;
    logic       req_valid = 1'b0;
    logic [1:0] req_drive = '0;
    logic       req_write = 1'b0;
    logic       busy, cyc_setup, cyc_rd, cyc_wr, done;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #5 clk = ~clk;

    pio_timing_gen uut (
        .clk(clk), .rst(rst), .rev_plus1(rev_plus1),
        .cfg_we(cfg_we), .cfg_setup_only(cfg_setup_only),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_drive(req_drive), .req_write(req_write),
        .busy(busy), .cyc_setup(cyc_setup), .cyc_rd(cyc_rd), .cyc_wr(cyc_wr),
        .done(done)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run hung, act=%0d exp<150000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // {drive[2], write, rev, setup[8], timing[8], s[5], a[5], r[5]}
    localparam int NV = 8;
    localparam logic [34:0] VEC [NV] = '{
        {2'd0, 1'b0, 1'b0, 8'h80, 8'h23, 5'd3, 5'd2,  5'd3},
        {2'd1, 1'b0, 1'b0, 8'h40, 8'h12, 5'd2, 5'd2,  5'd2},
        {2'd0, 1'b1, 1'b0, 8'hC0, 8'h41, 5'd5, 5'd4,  5'd2},
        {2'd1, 1'b0, 1'b0, 8'h00, 8'h31, 5'd4, 5'd3,  5'd1},
        {2'd2, 1'b0, 1'b1, 8'h80, 8'h05, 5'd3, 5'd16, 5'd6},
        {2'd3, 1'b1, 1'b1, 8'h40, 8'h50, 5'd2, 5'd5,  5'd17},
        {2'd0, 1'b0, 1'b0, 8'h3F, 8'h11, 5'd4, 5'd2,  5'd1},
        {2'd2, 1'b1, 1'b0, 8'hC0, 8'hF0, 5'd5, 5'd15, 5'd16}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d, input logic so);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_setup_only = so;
        @(negedge clk);
        cfg_we = 1'b0; cfg_setup_only = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        cfg_raddr = a;
        #1 d = cfg_rdata;
    endtask

    // inj_kind: 0 none, 1 request for drive inj_d, 2 register write
    task automatic run_cycle(input logic [1:0] d, input logic w,
                             input int inj_k, input int inj_kind,
                             input logic [2:0] inj_a, input logic [7:0] inj_v,
                             output int s, output int a, output int r, output int bad);
        int ph;
        s = 0; a = 0; r = 0; bad = 0; ph = 0;
        @(negedge clk);
        req_valid = 1'b1; req_drive = d; req_write = w;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 200; k++) begin
            logic v_s, v_rd, v_wr, v_b, v_d;
            v_s = cyc_setup; v_rd = cyc_rd; v_wr = cyc_wr; v_b = busy; v_d = done;
            req_valid = 1'b0; cfg_we = 1'b0;
            if (v_d) break;
            if (!v_b) bad++;
            if (v_s) begin
                s++; if (ph > 0) bad++;
            end else if (v_rd || v_wr) begin
                a++; if (ph > 1) bad++; ph = 1;
                if (v_rd == w || v_wr != w) bad++;
            end else if (v_b) begin
                r++; ph = 2;
            end
            if (k == inj_k && inj_kind == 1) begin
                req_valid = 1'b1; req_drive = ~d; req_write = ~w;
            end
            if (k == inj_k && inj_kind == 2) begin
                cfg_we = 1'b1; cfg_addr = inj_a; cfg_wdata = inj_v; cfg_setup_only = 1'b0;
            end
            @(negedge clk);
        end
        req_valid = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic expect_cycle(input string req, input logic [1:0] d, input logic w,
                                input int es, input int ea, input int er);
        int s, a, r, bad;
        run_cycle(d, w, -1, 0, 3'd0, 8'd0, s, a, r, bad);
        chk({req, " setup"}, s, es);
        chk({req, " active"}, a, ea);
        chk({req, " recovery"}, r, er);
        chk({req, " order"}, bad, 0);
    endtask

    initial begin
        logic [7:0] rv;
        int s, a, r, bad;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 strobes", int'({cyc_setup, cyc_rd, cyc_wr}), 0);
        for (int i = 0; i < 6; i++) begin
            rd_reg(3'(i), rv);
            chk("R1 register readback", int'(rv), 0);
        end
        expect_cycle("R1 default d2", 2'd2, 1'b0, 4, 16, 16);
        expect_cycle("R1 default d0", 2'd0, 1'b1, 4, 16, 16);

        // R2 R4 R5 R6 R7 R8 R9: table walk
        for (int i = 0; i < NV; i++) begin
            logic [34:0] v;
            logic [1:0]  bk;
            v  = VEC[i];
            bk = v[34] ? 2'd2 : {1'b0, v[33]};
            wr_reg({bk, 1'b0}, v[30:23], 1'b0);
            wr_reg({bk, 1'b1}, v[22:15], 1'b0);
            rev_plus1 = v[31];
            expect_cycle($sformatf("R2/R4/R5/R6/R7/R9 vec%0d", i),
                         v[34:33], v[32], int'(v[14:10]), int'(v[9:5]), int'(v[4:0]));
        end
        rev_plus1 = 1'b0;

        // R3: setup-only writes keep bits [5:0]
        wr_reg(3'd0, 8'h2A, 1'b0);
        wr_reg(3'd0, 8'hC0, 1'b1);
        rd_reg(3'd0, rv);
        chk("R3 setup-only keeps low bits", int'(rv), 'hEA);
        wr_reg(3'd0, 8'h15, 1'b1);
        rd_reg(3'd0, rv);
        chk("R3 setup-only clears code", int'(rv), 'h2A);
        wr_reg(3'd0, 8'h80, 1'b0);
        rd_reg(3'd0, rv);
        chk("R3 full write", int'(rv), 'h80);

        // R11: mid-cycle write to bank 1 timing (drive 1 is 4/3/1)
        run_cycle(2'd1, 1'b0, 2, 2, 3'd3, 8'h22, s, a, r, bad);
        chk("R11 current setup", s, 4);
        chk("R11 current active", a, 3);
        chk("R11 current recovery", r, 1);
        expect_cycle("R11 next", 2'd1, 1'b0, 4, 2, 2);

        // R10: request while busy is dropped (drive 0: setup 0x80, timing 0x11)
        run_cycle(2'd0, 1'b0, 3, 1, 3'd0, 8'd0, s, a, r, bad);
        chk("R10 setup", s, 3);
        chk("R10 active", a, 2);
        chk("R10 recovery", r, 1);
        chk("R10 order", bad, 0);
        @(negedge clk);
        chk("R10 stays idle", int'(busy), 0);
        @(negedge clk);
        chk("R10 single done", int'(done), 0);

        // R8: drives 2 and 3 share bank 2; bank 0 does not touch drive 1
        expect_cycle("R8 drive3 shared", 2'd3, 1'b0, 5, 15, 16);
        wr_reg(3'd5, 8'h23, 1'b0);
        expect_cycle("R8 drive2 shared", 2'd2, 1'b1, 5, 2, 3);
        expect_cycle("R8 drive3 follows", 2'd3, 1'b0, 5, 2, 3);
        wr_reg(3'd1, 8'h77, 1'b0);
        expect_cycle("R8 drive1 own bank", 2'd1, 1'b0, 4, 2, 2);
        wr_reg(3'd7, 8'h99, 1'b0);
        rd_reg(3'd7, rv);
        chk("R8 bank3 not writable", int'(rv), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule